// File: doc/BRIEF.md
# SDRAM Clock-Enable and Power-Down Controller

This block sits on the device side of a synchronous DRAM. On every rising clock edge it samples the clock-enable pin together with a status input that says whether every bank is idle. From these two inputs it decides how the rest of the device behaves in the following cycle. There are three outcomes: normal operation, a clock suspend (output and burst-address state frozen, other inputs ignored) or power-down.

A low clock enable never acts on the edge that samples it. The command presented at that edge is still taken, and the change starts one cycle later. The meaning of the low level depends on the banks at that edge. If every bank is idle, the device goes into power-down. If any bank is open, the clock is only suspended. Once either condition has started, it lasts for as long as the pin stays low, and changes on the bank-idle input make no difference. The device leaves it when the pin is sampled high again. The edge after that is the first one whose command is taken, so a controller raises the pin one cycle before it wants to issue a command.

The controller is a three-state machine. The states are RUN (commands accepted), HOLD (clock suspended) and SLEEP (power-down). It has four transitions:
- ENTER_HOLD: RUN to HOLD, on a low sample while a bank is open.
- ENTER_SLEEP: RUN to SLEEP, on a low sample while all banks are idle.
- WAKE: HOLD or SLEEP to RUN, on a high sample.
- STAY: every other case, which keeps the current state.

All four outputs come straight from flip-flops.

Top module: `cke_pd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are cmd_accept=1, freeze=0, suspend=0, power_down=0. The clock-enable pin is treated as high until it is sampled.
- R2: In RUN, an edge that samples cke=1 leaves cmd_accept=1 and the other three outputs at 0 after that edge.
- R3: In RUN, an edge that samples cke=0 with banks_idle=0 moves the block to HOLD. The change shows only after that edge: suspend=1, freeze=1, cmd_accept=0, power_down=0.
- R4: In RUN, an edge that samples cke=0 with banks_idle=1 moves the block to SLEEP. The change shows only after that edge: power_down=1, freeze=1, cmd_accept=0, suspend=0.
- R5: In HOLD, every edge that samples cke=0 keeps HOLD, whatever value banks_idle has. HOLD never turns into SLEEP directly.
- R6: In SLEEP, every edge that samples cke=0 keeps SLEEP, whatever value banks_idle has.
- R7: In HOLD or SLEEP, an edge that samples cke=1 returns the block to RUN. From then on cmd_accept=1 and the other outputs are 0, so the command at the next edge is accepted.
- R8: suspend and power_down are never both high. freeze equals their OR, and cmd_accept equals the inverse of freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| banks_idle | input | 1 | High when no bank is open |
| cmd_accept | output | 1 | The command at the next edge may be taken |
| freeze | output | 1 | Hold the output state and the burst address counter |
| suspend | output | 1 | Clock suspend in progress |
| power_down | output | 1 | Power-down in progress |

## Verification
Two functions can meet at a single edge: leaving a clock suspend and entering power-down. They also meet in the reverse order, leaving power-down and entering a clock suspend. The bench provokes each case by pulsing cke high for exactly one cycle between two low stretches. banks_idle changes while the pin is low, so the second low sample meets a different bank status from the first. At each negative edge, the bench compares the outputs with a behavioural model. That model must show exactly one RUN cycle, and then the kind of entry chosen by the bank status at the second low sample. A long stretch of pseudo-random cke and banks_idle values also hits these back-to-back edges many times.

// File: rtl/ckectl_pkg.sv
package ckectl_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SLEEP = 2'd2
    } cke_state_e;

    typedef struct packed {
        logic accept;
        logic freeze;
        logic hold;
        logic sleep;
    } cke_flags_t;

    localparam cke_flags_t FLAGS_RUN   = '{accept: 1'b1, freeze: 1'b0, hold: 1'b0, sleep: 1'b0};
    localparam cke_flags_t FLAGS_HOLD  = '{accept: 1'b0, freeze: 1'b1, hold: 1'b1, sleep: 1'b0};
    localparam cke_flags_t FLAGS_SLEEP = '{accept: 1'b0, freeze: 1'b1, hold: 1'b0, sleep: 1'b1};

endpackage

// File: rtl/cke_next_state.sv
module cke_next_state
    import ckectl_pkg::*;
(
    input  cke_state_e state,
    input  logic       cke,
    input  logic       banks_idle,
    output cke_state_e nxt
);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                // ENTER_SLEEP / ENTER_HOLD: a low sample takes effect next cycle
                if (!cke) begin
                    nxt = banks_idle ? ST_SLEEP : ST_HOLD;
                end
            end
            ST_HOLD, ST_SLEEP: begin
                // WAKE: a high sample returns to RUN; bank status is ignored
                if (cke) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

endmodule

// File: rtl/cke_state_reg.sv
module cke_state_reg
    import ckectl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cke_state_e nxt,
    output cke_state_e state
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/cke_flag_reg.sv
module cke_flag_reg
    import ckectl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cke_state_e nxt,
    output cke_flags_t flags
);

    cke_flags_t flags_d;

    always_comb begin
        unique case (nxt)
            ST_RUN:   flags_d = FLAGS_RUN;
            ST_HOLD:  flags_d = FLAGS_HOLD;
            ST_SLEEP: flags_d = FLAGS_SLEEP;
            default:  flags_d = FLAGS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= FLAGS_RUN;
        end else begin
            flags <= flags_d;
        end
    end

endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
    import ckectl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic banks_idle,
    output logic cmd_accept,
    output logic freeze,
    output logic suspend,
    output logic power_down
);

    cke_state_e state;
    cke_state_e nxt;
    cke_flags_t flags;

    cke_next_state u_next (
        .state      (state),
        .cke        (cke),
        .banks_idle (banks_idle),
        .nxt        (nxt)
    );

    cke_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .state (state)
    );

    cke_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .flags (flags)
    );

    assign cmd_accept = flags.accept;
    assign freeze     = flags.freeze;
    assign suspend    = flags.hold;
    assign power_down = flags.sleep;

endmodule

// File: rtl/cke_pd_ctrl_chk.sv
module cke_pd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic banks_idle,
    input logic cmd_accept,
    input logic freeze,
    input logic suspend,
    input logic power_down
);

    p_run_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cke) |=> (cmd_accept && !freeze));

    p_enter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && !cke && !banks_idle) |=> (suspend && !power_down && !cmd_accept));

    p_enter_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && !cke && banks_idle) |=> (power_down && !suspend && !cmd_accept));

    p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !cke) |=> (suspend && !power_down));

    p_sleep_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (power_down && !cke) |=> (power_down && !suspend));

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((suspend || power_down) && cke) |=> (cmd_accept && !suspend && !power_down));

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(suspend && power_down) && (freeze == (suspend || power_down)) && (cmd_accept == !freeze));

endmodule

bind cke_pd_ctrl cke_pd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .banks_idle (banks_idle),
    .cmd_accept (cmd_accept),
    .freeze     (freeze),
    .suspend    (suspend),
    .power_down (power_down)
);

// File: tb/cke_pd_ctrl_bench.sv
`timescale 1ns/1ps
module cke_pd_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1;
    logic banks_idle = 1'b0;
    logic cmd_accept, freeze, suspend, power_down;

    int checks = 0;
    int errors = 0;
    int mode = 0;          // 0 run, 1 suspended, 2 powered down
    string tag = "R1";
    int unsigned lfsr = 32'hACE1_2357;

    always #2 clk = ~clk;  // 250 MHz

    cke_pd_ctrl u_cke_pd_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .banks_idle (banks_idle),
        .cmd_accept (cmd_accept),
        .freeze     (freeze),
        .suspend    (suspend),
        .power_down (power_down)
    );

    task automatic compare();
        logic [3:0] exp_v, act_v;
        exp_v = {mode == 0, mode != 0, mode == 1, mode == 2};
        act_v = {cmd_accept, freeze, suspend, power_down};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s t=%0t {accept,freeze,suspend,pd} actual=%b expected=%b",
                     tag, $time, act_v, exp_v);
        end
        checks++;
        if ((suspend && power_down) || (freeze != (suspend || power_down)) || (cmd_accept != !freeze)) begin
            errors++;
            $display("FAIL R8 t=%0t inconsistent flags actual=%b expected one-hot-consistent",
                     $time, act_v);
        end
    endtask

    task automatic step(input logic c, input logic idle);
        cke = c;
        banks_idle = idle;
        @(posedge clk);
        if (mode == 0)      tag = c ? "R2" : (idle ? "R4" : "R3");
        else if (mode == 1) tag = c ? "R7" : "R5";
        else                tag = c ? "R7" : "R6";
        if (mode == 0) begin
            if (!c) mode = idle ? 2 : 1;
        end else if (c) begin
            mode = 0;
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with cke low during reset
        cke = 1'b0;
        banks_idle = 1'b1;
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        cke = 1'b1;
        @(negedge clk);
        tag = "R1";
        mode = 0;
        compare();

        // R2: steady run
        step(1, 0); step(1, 1); step(1, 0);
        // R3 then R5 with bank status moving, then R7
        step(0, 0); step(0, 1); step(0, 0); step(0, 1); step(1, 1);
        // R4 then R6 with bank status moving, then R7
        step(0, 1); step(0, 0); step(0, 1); step(1, 0);
        // R7 exit then immediate R4 entry (suspend exit meets power-down entry)
        step(0, 0); step(0, 1); step(1, 1); step(0, 1); step(0, 0); step(1, 0);
        // power-down exit then immediate suspend entry
        step(0, 1); step(1, 0); step(0, 0); step(1, 0);
        // mixed pseudo-random stretch
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3] | lfsr[7], lfsr[5]);
        end
        // reset again from power-down
        step(0, 1);
        rst_n = 1'b0;
        mode = 0;
        #1;
        tag = "R1";
        compare();
        @(negedge clk);
        rst_n = 1'b1;
        cke = 1'b1;
        step(1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule